// File: doc/BRIEF.md
# Head-of-Queue Cache with Largest-Deficit Refill

This block serves the head cells of several FIFO queues from a small on-chip cache. The bodies of those queues sit in a slow, wide memory. Each cycle an external scheduler may name any queue. If that queue has a cell in the cache, the block hands the cell back on the next cycle. The block keeps no request pipeline deeper than the registered read of the cell store.

Behind the cache, the slow memory is modelled as one access path shared by all banks. Each access returns `BLK` consecutive cells of one queue, and a new access may start at most once every `BLK` cycles. When an access slot is free, the block chooses the queue with the largest deficit. The deficit is measured as the fewest cells held or already on their way. The block then issues a refill request. The slow memory answers after a fixed latency with `BLK` cells on consecutive cycles, and the block appends them to that queue's region of the cache.

The scheduler's request order is arbitrary. After the caches have been filled, choosing the neediest queue keeps every queue stocked well enough that no request finds an empty cache.

Top module: `head_cache_mdf`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rsp_valid`, `refill_req` and `underrun` are low. All cached and in-flight cell counts restart from zero.
- R2: A request (`sched_valid` high) for a queue holding at least one cached cell raises `rsp_valid` in the next cycle, with that queue's oldest cached cell on `rsp_data`. Each cell is delivered exactly once.
- R3: A request for a queue with no cached cell produces no response. It sets `underrun`, which stays high until reset.
- R4: Two cycles with `refill_req` high are at least `BLK` cycles apart. `refill_req` is a one-cycle pulse. The block issues a refill as soon as an access slot is free and some queue is eligible.
- R5: A refill goes to the eligible queue with the smallest count of cached plus in-flight cells. Equal counts go to the lowest queue index. `refill_q` names the queue in the cycle `refill_req` is high.
- R6: A queue is not eligible while its `body_avail` bit is low. It is also not eligible while its cached plus in-flight count exceeds `DEPTH-BLK`. When no queue is eligible, no refill is issued.
- R7: The slow memory presents the `BLK` cells of a refill on `fill_data`, one per cycle. The first cell arrives `LAT` cycles after the cycle in which `refill_req` was high. The block stores them in arrival order behind the queue's existing cells.
- R8: The default sizes meet `NQ*DEPTH >= NQ*BLK*(2+ln NQ)`. Start from all caches full, with `body_avail` high and at most one request per cycle. Under that condition, no request sequence sets `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_valid | input | 1 | Scheduler requests a head cell this cycle |
| sched_q | input | QW | Queue named by the request |
| body_avail | input | NQ | Per queue: slow memory holds at least one block for it |
| fill_data | input | CW | Refill cell from slow memory, fixed-latency beats |
| rsp_valid | output | 1 | Head cell returned |
| rsp_data | output | CW | Returned head cell |
| underrun | output | 1 | Sticky: a request found an empty cache |
| refill_req | output | 1 | One-cycle refill request to slow memory |
| refill_q | output | QW | Queue to be refilled |

## Verification
The hardest state to reach is a queue driven down to its lowest cache level while its own refills are still in flight. At that point an off-by-one in the deficit accounting or in the arrival window would show up as an underrun or a wrong cell. To get there, the bench first lets every cache fill. It then runs an adversary that, each cycle, requests whichever queue its own model says holds the fewest cached cells. Single-queue hammering and random traffic follow. Finally the bench cuts `body_avail` for one queue and drains it, to force a genuine underrun and show that the starved queue is never chosen.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int HC_NQ    = 4;
  localparam int HC_DEPTH = 32;
  localparam int HC_BLK   = 4;
  localparam int HC_LAT   = 3;
  localparam int HC_CW    = 16;

  // Total cache needed for zero-delay service under any request order.
  function automatic bit cap_ok(input int nq, input int depth, input int blk);
    real need;
    need = real'(nq) * real'(blk) * (2.0 + $ln(real'(nq)));
    return real'(nq * depth) >= need;
  endfunction
endpackage

// File: rtl/hc_queue_track.sv
module hc_queue_track #(
  parameter int DEPTH = 32,
  parameter int BLK   = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop,
  input  logic            push,
  input  logic            reserve,
  output logic [PW-1:0]   rd_ptr,
  output logic [PW-1:0]   wr_ptr,
  output logic [CNTW-1:0] cached,
  output logic [CNTW-1:0] occ
);
  logic [CNTW-1:0] pending;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cached  <= '0;
      pending <= '0;
    end else begin
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      cached  <= cached + CNTW'(push) - CNTW'(pop);
      pending <= pending + (reserve ? CNTW'(BLK) : CNTW'(0)) - CNTW'(push);
    end
  end

  assign occ = cached + pending;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    occ <= CNTW'(DEPTH));
  assert_push_backed_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> (pending != '0));
  assert_pop_hit_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cached != '0));
endmodule

// File: rtl/hc_mdf_pick.sv
module hc_mdf_pick #(
  parameter int NQ    = 4,
  parameter int DEPTH = 32,
  parameter int BLK   = 4,
  parameter int QW    = 2,
  parameter int CNTW  = 6
) (
  input  logic [NQ-1:0][CNTW-1:0] occ,
  input  logic [NQ-1:0]           body_avail,
  output logic                    any_ok,
  output logic [QW-1:0]           pick
);
  logic [NQ-1:0]   elig;
  logic [CNTW-1:0] best;

  for (genvar g = 0; g < NQ; g++) begin : g_elig
    assign elig[g] = body_avail[g] && (occ[g] <= CNTW'(DEPTH - BLK));
  end

  // Strict less-than keeps the lowest index on ties.
  always_comb begin
    any_ok = 1'b0;
    pick   = '0;
    best   = '0;
    for (int i = 0; i < NQ; i++) begin
      if (elig[i] && (!any_ok || occ[i] < best)) begin
        any_ok = 1'b1;
        pick   = QW'(i);
        best   = occ[i];
      end
    end
  end
endmodule

// File: rtl/hc_refill_seq.sv
module hc_refill_seq #(
  parameter int BLK = 4,
  parameter int LAT = 3,
  parameter int QW  = 2,
  localparam int CBW = $clog2(BLK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_ok,
  input  logic [QW-1:0] pick,
  output logic          issue,
  output logic          refill_req,
  output logic [QW-1:0] refill_q,
  output logic          cap,
  output logic [QW-1:0] cap_q
);
  logic [CBW-1:0]          cool;
  logic [CBW-1:0]          beats;
  logic [LAT-1:0]          pipe_v;
  logic [LAT-1:0][QW-1:0]  pipe_q;

  assign issue = any_ok && (cool == '0);
  assign cap   = (beats != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cool       <= '0;
      beats      <= '0;
      refill_req <= 1'b0;
      refill_q   <= '0;
      cap_q      <= '0;
      pipe_v     <= '0;
      pipe_q     <= '0;
    end else begin
      refill_req <= issue;
      if (issue) refill_q <= pick;
      if (issue)              cool <= CBW'(BLK - 1);
      else if (cool != '0)    cool <= cool - 1'b1;
      pipe_v[0] <= issue;
      pipe_q[0] <= pick;
      for (int i = 1; i < LAT; i++) begin
        pipe_v[i] <= pipe_v[i-1];
        pipe_q[i] <= pipe_q[i-1];
      end
      if (pipe_v[LAT-1]) begin
        beats <= CBW'(BLK);
        cap_q <= pipe_q[LAT-1];
      end else if (beats != '0) begin
        beats <= beats - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hc_cell_ram.sv
module hc_cell_ram #(
  parameter int WORDS = 128,
  parameter int CW    = 16,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/head_cache_mdf.sv
module head_cache_mdf #(
  parameter int NQ    = hc_pkg::HC_NQ,
  parameter int DEPTH = hc_pkg::HC_DEPTH,
  parameter int BLK   = hc_pkg::HC_BLK,
  parameter int LAT   = hc_pkg::HC_LAT,
  parameter int CW    = hc_pkg::HC_CW,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sched_valid,
  input  logic [QW-1:0] sched_q,
  input  logic [NQ-1:0] body_avail,
  input  logic [CW-1:0] fill_data,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_data,
  output logic          underrun,
  output logic          refill_req,
  output logic [QW-1:0] refill_q
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CNTW  = $clog2(DEPTH + 1);
  localparam int WORDS = NQ * DEPTH;
  localparam int AW    = $clog2(WORDS);
  localparam int CBW   = $clog2(BLK + 1);

  logic [NQ-1:0][PW-1:0]   rd_ptr_all, wr_ptr_all;
  logic [NQ-1:0][CNTW-1:0] cached_all, occ_all;
  logic [NQ-1:0]           pop, push, reserve;
  logic                    q_ok, hit, any_ok, issue, cap;
  logic [QW-1:0]           pick, cap_q;
  logic [AW-1:0]           raddr, waddr;

  assign q_ok = ({1'b0, sched_q} < (QW+1)'(NQ));
  assign hit  = sched_valid && q_ok && (cached_all[sched_q] != '0);

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign pop[g]     = hit && (sched_q == QW'(g));
    assign push[g]    = cap && (cap_q == QW'(g));
    assign reserve[g] = issue && (pick == QW'(g));
    hc_queue_track #(.DEPTH(DEPTH), .BLK(BLK)) u_trk (
      .clk(clk), .rst(rst), .pop(pop[g]), .push(push[g]), .reserve(reserve[g]),
      .rd_ptr(rd_ptr_all[g]), .wr_ptr(wr_ptr_all[g]),
      .cached(cached_all[g]), .occ(occ_all[g]));
  end

  hc_mdf_pick #(.NQ(NQ), .DEPTH(DEPTH), .BLK(BLK), .QW(QW), .CNTW(CNTW)) u_pick (
    .occ(occ_all), .body_avail(body_avail), .any_ok(any_ok), .pick(pick));

  hc_refill_seq #(.BLK(BLK), .LAT(LAT), .QW(QW)) u_seq (
    .clk(clk), .rst(rst), .any_ok(any_ok), .pick(pick), .issue(issue),
    .refill_req(refill_req), .refill_q(refill_q), .cap(cap), .cap_q(cap_q));

  assign raddr = AW'(sched_q) * AW'(DEPTH) + AW'(rd_ptr_all[sched_q]);
  assign waddr = AW'(cap_q) * AW'(DEPTH) + AW'(wr_ptr_all[cap_q]);

  hc_cell_ram #(.WORDS(WORDS), .CW(CW), .AW(AW)) u_ram (
    .clk(clk), .we(cap), .waddr(waddr), .wdata(fill_data),
    .re(hit), .raddr(raddr), .rdata(rsp_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      rsp_valid <= hit;
      if (sched_valid && !hit) underrun <= 1'b1;
    end
  end

  // Observation registers used only by the properties below.
  logic [CBW-1:0] gap;
  logic [NQ-1:0]  body_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap    <= CBW'(BLK);
      body_d <= '0;
    end else begin
      body_d <= body_avail;
      if (refill_req)              gap <= CBW'(1);
      else if (gap < CBW'(BLK))    gap <= gap + 1'b1;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(sched_valid));
  assert_underrun_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  assert_refill_gap_R4: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (gap >= CBW'(BLK)));
  assert_refill_eligible_R6: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> body_d[refill_q]);
endmodule

// File: tb/sim_head_cache_mdf.sv
`timescale 1ns/1ps
module sim_head_cache_mdf;
  localparam int NQ = hc_pkg::HC_NQ;
  localparam int D  = hc_pkg::HC_DEPTH;
  localparam int B  = hc_pkg::HC_BLK;
  localparam int L  = hc_pkg::HC_LAT;
  localparam int CW = hc_pkg::HC_CW;
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, sv, rsp_valid, underrun, refill_req;
  logic [QW-1:0] sq, refill_q;
  logic [NQ-1:0] body;
  logic [CW-1:0] fill, rsp_data;

  head_cache_mdf u0 (
    .clk(clk), .rst(rst), .sched_valid(sv), .sched_q(sq), .body_avail(body),
    .fill_data(fill), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .underrun(underrun), .refill_req(refill_req), .refill_q(refill_q));

  int errs = 0, checks = 0, n = 0;
  bit done = 0;

  // Reference model state
  logic [CW-1:0] mc [NQ][$];
  int pend [NQ];
  int seq  [NQ];
  int cool;
  bit exp_rv, exp_req, exp_under;
  logic [CW-1:0] exp_rd;
  int exp_q;
  int mb_cyc[$], mb_q[$];          // model's expected arrival schedule
  int sm_cyc[$];                   // slow memory return schedule
  logic [CW-1:0] sm_dat[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle=%0d act=%0h exp=%0h", tag, n, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) begin mc[i].delete(); pend[i] = 0; seq[i] = 0; end
    cool = 0; exp_rv = 0; exp_req = 0; exp_under = 0; exp_q = 0; exp_rd = '0;
    mb_cyc.delete(); mb_q.delete(); sm_cyc.delete(); sm_dat.delete();
  endtask

  task automatic compare();
    chk(rsp_valid === exp_rv, "R2 rsp_valid", int'(rsp_valid), int'(exp_rv));
    if (exp_rv) chk(rsp_data === exp_rd, "R7 rsp_data order", int'(rsp_data), int'(exp_rd));
    chk(underrun === exp_under, "R3 underrun", int'(underrun), int'(exp_under));
    chk(refill_req === exp_req, "R4 refill_req timing", int'(refill_req), int'(exp_req));
    if (exp_req) chk(int'(refill_q) == exp_q, "R5 R6 refill_q choice", int'(refill_q), exp_q);
  endtask

  task automatic model_step();
    bit iss = 0; int iq = 0, best = 0;
    if (cool == 0) begin
      for (int i = 0; i < NQ; i++) begin
        int occ = mc[i].size() + pend[i];
        if (body[i] && occ <= D - B && (!iss || occ < best)) begin
          iss = 1; iq = i; best = occ;
        end
      end
    end
    exp_req = iss;
    if (iss) begin
      exp_q = iq; pend[iq] += B; cool = B - 1;
      for (int j = 0; j < B; j++) begin mb_cyc.push_back(n + L + 1 + j); mb_q.push_back(iq); end
    end else if (cool > 0) cool--;
    exp_rv = 0;
    if (sv) begin
      if (mc[int'(sq)].size() > 0) begin exp_rv = 1; exp_rd = mc[int'(sq)].pop_front(); end
      else exp_under = 1;
    end
    if (mb_cyc.size() > 0 && mb_cyc[0] == n) begin
      mc[mb_q[0]].push_back(fill);
      pend[mb_q[0]]--;
      void'(mb_cyc.pop_front()); void'(mb_q.pop_front());
    end
  endtask

  task automatic drive(input int mode);
    int lo = -1;
    // slow memory: schedule a block when a request is seen
    if (refill_req) begin
      for (int j = 0; j < B; j++) begin
        sm_cyc.push_back(n + L + j);
        sm_dat.push_back(CW'((int'(refill_q) << 12) | (seq[int'(refill_q)] & 12'hFFF)));
        seq[int'(refill_q)]++;
      end
    end
    fill = 16'hFFFF;
    if (sm_cyc.size() > 0 && sm_cyc[0] == n) begin
      fill = sm_dat[0]; void'(sm_cyc.pop_front()); void'(sm_dat.pop_front());
    end
    sv = 0; sq = '0;
    case (mode)
      1: begin sv = 1; sq = QW'(1); end
      2: begin sv = 1; sq = QW'(n % NQ); end
      3: begin
        for (int i = 0; i < NQ; i++)
          if (mc[i].size() > 0 && (lo < 0 || mc[i].size() < mc[lo].size())) lo = i;
        if (lo >= 0) begin sv = 1; sq = QW'(lo); end
      end
      4: begin sv = (($urandom % 5) != 0); sq = QW'($urandom % NQ); end
      5: begin sv = 1; sq = QW'(2); end
      default: ;
    endcase
  endtask

  task automatic run(input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      compare();
      drive(mode);
      model_step();
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1; sv = 0; sq = '0; body = '1; fill = 16'hFFFF;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    chk(!rsp_valid && !refill_req && !underrun, "R1 reset outputs",
        int'({rsp_valid, refill_req, underrun}), 0);
    chk(hc_pkg::cap_ok(NQ, D, B), "R8 capacity bound", 0, 1);
    run(0, 200);   // warm-up: refills from queue 0 upward (R5 ties), stop when full (R6)
    run(1, 300);   // hammer one queue
    run(2, 300);   // rotate
    run(3, 1000);  // adversary: always the emptiest queue
    run(4, 1000);  // random
    chk(underrun === 1'b0, "R8 no underrun under pressure", int'(underrun), 0);
    body[2] = 1'b0;
    run(5, 80);    // drain starved queue: never refilled (R6), then misses
    chk(underrun === 1'b1, "R3 starved queue underrun", int'(underrun), 1);
    run(0, 20);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    body = '1;
    chk(!underrun && !rsp_valid && !refill_req, "R1 reset clears underrun",
        int'({rsp_valid, refill_req, underrun}), 0);
    run(0, 100);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule